// File: doc/BRIEF.md
# I2C Serial EEPROM Slave

This block is a synthesizable two-wire serial slave that gives an I2C bus access to an internal byte memory. The memory holds 2^ADDR_BITS bytes, for example 4096 or 8192. The bus clock and data lines reach the block as plain sampled inputs, already synchronised to the system clock. The block answers through a single pull-low output, which the pad turns into an open-drain SDA driver. Three strap inputs give the device's position on a shared bus. A write-protect input locks the whole array.

A master first selects the device by its address byte. For a write, it then sends a two-byte word address and any number of data bytes. Those bytes collect in a page buffer. They reach the array only after the STOP that ends the sequence, during a self-timed programming interval whose length is set by a parameter. During that interval the device keeps SDA released and does not answer its address. Reads come out of the memory at the current pointer. A random read is a write that carries only the word address, followed by a repeated START and a read.

The bus has no valid/ready handshake and no back-pressure: the block never holds SCL low. The master sets the pace, and the block samples on rising SCL and changes SDA only while SCL is low. All other pins are plain control levels.

Top module: `eep_i2c_slave`

## Requirements
- R1: An SDA change while SCL is high is a bus condition, never a data bit. SDA falling is a START. A START seen in the middle of a byte abandons that byte and restarts address reception.
- R2: Out of reset or after a STOP, the block ignores SCL pulses and data until a START arrives, and does not acknowledge any byte clocked without one.
- R3: The first byte after a START is the address byte, sent MSB first. Bits 7..4 must be 1010 and bits 3..1 must equal the strap input bits 2..0. Bit 0 set to 1 selects a read and 0 selects a write. A mismatch gets no acknowledge.
- R4: The block acknowledges a matching address byte, and in a write every following byte, by pulling SDA low during the ninth SCL pulse. The pull output changes only while SCL is low.
- R5: In a write, the two bytes after the address byte form the word pointer, high byte first. Only the low ADDR_BITS bits are kept, so with 12 address bits the pointers 0xF123 and 0x0123 are the same.
- R6: Data bytes of a write go into a PAGE_BYTES page buffer and reach the array only after the STOP. Within a sequence, the low log2(PAGE_BYTES) pointer bits step after each byte and wrap inside the page, so a later byte overwrites an earlier byte at the same offset.
- R7: After a STOP that commits buffered data, the block does not acknowledge its address for PROG_CYCLES clock cycles. Afterwards it answers normally.
- R8: When wp_i is high at the STOP, nothing is programmed, the array keeps its old contents and no busy interval follows. Data bytes are still acknowledged.
- R9: In a read, each byte is driven MSB first from the pointer, which then advances and wraps from the last address to 0. After a master acknowledge the next byte follows. After a missing acknowledge the block releases SDA until the next START or STOP.
- R10: A repeated START keeps the word pointer, so a read that follows it starts at the address the preceding write set.
- R11: A START on a non-busy device discards buffered write data that no STOP has committed.
- R12: A STOP returns the block to idle from any state, with SDA released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Sampled bus clock level |
| sda_i | input | 1 | Sampled bus data level (wired line) |
| sda_pull_o | output | 1 | 1 pulls SDA low, 0 releases it |
| dev_sel_i | input | 3 | Device strap bits, compared with address bits 3..1 |
| wp_i | input | 1 | 1 blocks all programming |

## Verification
Page writes are tried with short runs inside a page, with a run that crosses the page end, and with a run one byte longer than the page. These separate correct in-page wrapping from spilling into the next page and from lost overwrites. Reads are exercised as random reads, as sequential reads across the top of the memory, and with a master that withholds its acknowledge; this shows the pointer advance, the address wrap and the release after a missing acknowledge. Address bytes that are wrong in the fixed bits, wrong in the strap bits, sent without a START, or sent while the device is busy each show a distinct reason for staying silent. Repeated STARTs placed mid-byte, after a bare pointer write and after buffered data separate pointer retention from discarding uncommitted data.

// File: rtl/eep_pkg.sv
package eep_pkg;
  localparam logic [3:0] DEV_TYPE = 4'b1010;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_AHI,
    ST_ALO,
    ST_WDATA,
    ST_RDATA,
    ST_WAIT
  } slv_state_t;
endpackage

// File: rtl/eep_bus_cond.sv
module eep_bus_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic start_o,
  output logic stop_o,
  output logic rise_o,
  output logic fall_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  // conditions need SCL high on both samples; edges of SCL are data timing
  assign start_o = scl_q & scl_i & sda_q & ~sda_i;
  assign stop_o  = scl_q & scl_i & ~sda_q & sda_i;
  assign rise_o  = ~scl_q & scl_i;
  assign fall_o  = scl_q & ~scl_i;
endmodule

// File: rtl/eep_page_buf.sv
module eep_page_buf #(
  parameter int PAGE_BYTES = 32,
  localparam int PAGE_BITS = $clog2(PAGE_BYTES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr_i,
  input  logic                 wr_i,
  input  logic [PAGE_BITS-1:0] wr_idx_i,
  input  logic [7:0]           wr_data_i,
  input  logic [PAGE_BITS-1:0] rd_idx_i,
  output logic [7:0]           rd_data_o,
  output logic                 rd_valid_o,
  output logic                 any_valid_o
);
  logic [7:0]            slot_q [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] valid_q;

  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        valid_q[g] <= 1'b0;
        slot_q[g]  <= 8'h00;
      end else if (clr_i) begin
        valid_q[g] <= 1'b0;
      end else if (wr_i && (wr_idx_i == PAGE_BITS'(g))) begin
        valid_q[g] <= 1'b1;
        slot_q[g]  <= wr_data_i;
      end
    end
  end

  assign rd_data_o   = slot_q[rd_idx_i];
  assign rd_valid_o  = valid_q[rd_idx_i];
  assign any_valid_o = |valid_q;
endmodule

// File: rtl/eep_prog_timer.sv
module eep_prog_timer #(
  parameter int PROG_CYCLES = 200,
  parameter int PAGE_BYTES  = 32,
  localparam int PAGE_BITS  = $clog2(PAGE_BYTES),
  localparam int CW         = $clog2(PROG_CYCLES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 go_i,
  output logic                 busy_o,
  output logic                 commit_en_o,
  output logic [PAGE_BITS-1:0] commit_idx_o
);
  logic          running_q;
  logic [CW-1:0] elapsed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running_q <= 1'b0;
      elapsed_q <= '0;
    end else if (go_i && !running_q) begin
      running_q <= 1'b1;
      elapsed_q <= '0;
    end else if (running_q) begin
      if (elapsed_q == CW'(PROG_CYCLES - 1)) running_q <= 1'b0;
      elapsed_q <= elapsed_q + CW'(1);
    end
  end

  // the first PAGE_BYTES cycles of the interval drain one slot each
  assign busy_o       = running_q;
  assign commit_en_o  = running_q && (int'(elapsed_q) < PAGE_BYTES);
  assign commit_idx_o = elapsed_q[PAGE_BITS-1:0];
endmodule

// File: rtl/eep_array.sv
module eep_array #(
  parameter int ADDR_BITS = 12,
  localparam int DEPTH    = 1 << ADDR_BITS
) (
  input  logic                 clk,
  input  logic                 we_i,
  input  logic [ADDR_BITS-1:0] waddr_i,
  input  logic [7:0]           wdata_i,
  input  logic [ADDR_BITS-1:0] raddr_i,
  output logic [7:0]           rdata_o
);
  logic [7:0] cell_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) cell_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = cell_q[raddr_i];
endmodule

// File: rtl/eep_i2c_slave.sv
module eep_i2c_slave
  import eep_pkg::*;
#(
  parameter int ADDR_BITS   = 12,
  parameter int PAGE_BYTES  = 32,
  parameter int PROG_CYCLES = 200
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_pull_o,
  input  logic [2:0] dev_sel_i,
  input  logic       wp_i
);
  localparam int PAGE_BITS = $clog2(PAGE_BYTES);

  logic start_w, stop_w, rise_w, fall_w;
  slv_state_t           state;
  logic [3:0]           bit_cnt;
  logic [7:0]           shreg;
  logic [7:0]           addr_hi_q;
  logic [ADDR_BITS-1:0] addr_q;
  logic                 ack_drive, tx_en, mack;
  logic [7:0]           tx_shift;
  logic                 busy, commit_en, commit_valid, pend, mem_we;
  logic [PAGE_BITS-1:0] commit_idx;
  logic [7:0]           commit_data, rdata;
  logic [15:0]          full_addr;
  logic                 rx_state, byte_done, dev_hit, buf_wr, prog_go;

  eep_bus_cond u_cond (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .start_o(start_w), .stop_o(stop_w), .rise_o(rise_w), .fall_o(fall_w)
  );

  assign rx_state  = (state == ST_DEV) || (state == ST_AHI) ||
                     (state == ST_ALO) || (state == ST_WDATA);
  assign byte_done = rx_state && fall_w && (bit_cnt == 4'd8);
  assign dev_hit   = (shreg[7:4] == DEV_TYPE) && (shreg[3:1] == dev_sel_i) && !busy;
  assign buf_wr    = byte_done && (state == ST_WDATA);
  assign prog_go   = stop_w && pend && !wp_i && !busy;
  assign full_addr = {addr_hi_q, shreg};

  eep_page_buf #(.PAGE_BYTES(PAGE_BYTES)) u_page (
    .clk(clk), .rst_n(rst_n),
    .clr_i(start_w && !busy),
    .wr_i(buf_wr), .wr_idx_i(addr_q[PAGE_BITS-1:0]), .wr_data_i(shreg),
    .rd_idx_i(commit_idx), .rd_data_o(commit_data), .rd_valid_o(commit_valid),
    .any_valid_o(pend)
  );

  eep_prog_timer #(.PROG_CYCLES(PROG_CYCLES), .PAGE_BYTES(PAGE_BYTES)) u_timer (
    .clk(clk), .rst_n(rst_n), .go_i(prog_go),
    .busy_o(busy), .commit_en_o(commit_en), .commit_idx_o(commit_idx)
  );

  assign mem_we = commit_en && commit_valid;

  eep_array #(.ADDR_BITS(ADDR_BITS)) u_array (
    .clk(clk), .we_i(mem_we),
    .waddr_i({addr_q[ADDR_BITS-1:PAGE_BITS], commit_idx}), .wdata_i(commit_data),
    .raddr_i(addr_q), .rdata_o(rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      bit_cnt   <= 4'd0;
      shreg     <= 8'h00;
      addr_hi_q <= 8'h00;
      addr_q    <= '0;
      ack_drive <= 1'b0;
      tx_en     <= 1'b0;
      tx_shift  <= 8'h00;
      mack      <= 1'b0;
    end else if (start_w) begin
      state     <= ST_DEV;
      bit_cnt   <= 4'd0;
      ack_drive <= 1'b0;
      tx_en     <= 1'b0;
    end else if (stop_w) begin
      state     <= ST_IDLE;
      bit_cnt   <= 4'd0;
      ack_drive <= 1'b0;
      tx_en     <= 1'b0;
    end else begin
      unique case (state)
        ST_DEV, ST_AHI, ST_ALO, ST_WDATA: begin
          if (rise_w && (bit_cnt < 4'd8)) begin
            shreg   <= {shreg[6:0], sda_i};
            bit_cnt <= bit_cnt + 4'd1;
          end else if (byte_done) begin
            bit_cnt   <= 4'd9;
            ack_drive <= 1'b1;
            case (state)
              ST_DEV: begin
                if (!dev_hit) begin
                  state     <= ST_WAIT;
                  ack_drive <= 1'b0;
                end else if (shreg[0]) begin
                  state <= ST_RDATA;
                  mack  <= 1'b1;
                end else begin
                  state <= ST_AHI;
                end
              end
              ST_AHI: begin
                addr_hi_q <= shreg;
                state     <= ST_ALO;
              end
              ST_ALO: begin
                addr_q <= full_addr[ADDR_BITS-1:0];
                state  <= ST_WDATA;
              end
              default: addr_q[PAGE_BITS-1:0] <= addr_q[PAGE_BITS-1:0] + PAGE_BITS'(1);
            endcase
          end else if (fall_w && (bit_cnt == 4'd9)) begin
            ack_drive <= 1'b0;
            bit_cnt   <= 4'd0;
          end
        end
        ST_RDATA: begin
          if (rise_w && (bit_cnt < 4'd8)) begin
            bit_cnt <= bit_cnt + 4'd1;
          end else if (rise_w && (bit_cnt == 4'd9)) begin
            mack <= ~sda_i;
          end else if (fall_w && (bit_cnt == 4'd9)) begin
            ack_drive <= 1'b0;
            if (mack) begin
              tx_shift <= rdata;
              tx_en    <= 1'b1;
              addr_q   <= addr_q + ADDR_BITS'(1);
              bit_cnt  <= 4'd0;
            end else begin
              state <= ST_WAIT;
              tx_en <= 1'b0;
            end
          end else if (fall_w && (bit_cnt == 4'd8)) begin
            tx_en   <= 1'b0;
            bit_cnt <= 4'd9;
          end else if (fall_w && (bit_cnt != 4'd0)) begin
            tx_shift <= {tx_shift[6:0], 1'b0};
          end
        end
        default: ;
      endcase
    end
  end

  assign sda_pull_o = ack_drive | (tx_en & ~tx_shift[7]);
endmodule

// File: rtl/eep_i2c_slave_chk.sv
module eep_i2c_slave_chk
  import eep_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       scl_i,
  input logic       sda_pull_o,
  input logic       busy,
  input logic       start_det,
  input logic       stop_det,
  input slv_state_t state,
  input logic       mem_we
);
  assert_start_to_dev_R1: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (state == ST_DEV));

  assert_pull_scl_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_pull_o) |-> !$past(scl_i));

  assert_commit_in_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> busy);

  assert_busy_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !sda_pull_o);

  assert_wait_released_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WAIT) |-> !sda_pull_o);

  assert_stop_to_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (state == ST_IDLE));
endmodule

bind eep_i2c_slave eep_i2c_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_pull_o(sda_pull_o),
  .busy(busy), .start_det(start_w), .stop_det(stop_w),
  .state(state), .mem_we(mem_we)
);

// File: tb/eep_i2c_slave_tb.sv
module eep_i2c_slave_tb;
  localparam int ABITS = 12;
  localparam int PROG  = 200;

  logic       clk = 1'b0, rst_n = 1'b0, scl = 1'b1, sda_m = 1'b1, wp = 1'b0;
  logic [2:0] dev_sel = 3'b101;
  logic       sda_pull;
  logic       sda_line;
  logic [7:0] rd_q [0:7];
  int         n_chk = 0, n_fail = 0;

  assign sda_line = sda_m & ~sda_pull;
  always #4 clk = ~clk;

  eep_i2c_slave #(.ADDR_BITS(ABITS), .PAGE_BYTES(32), .PROG_CYCLES(PROG)) u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
    .sda_pull_o(sda_pull), .dev_sel_i(dev_sel), .wp_i(wp)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic q();
    repeat (4) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; q(); scl = 1'b1; q(); sda_m = 1'b0; q(); scl = 1'b0; q();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; q(); scl = 1'b1; q(); sda_m = 1'b1; q();
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i]; q(); scl = 1'b1; q(); scl = 1'b0; q();
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    send_bits(b, 8);
    sda_m = 1'b1; q(); scl = 1'b1; q();
    acked = (sda_line == 1'b0);
    scl = 1'b0; q();
  endtask

  task automatic recv_byte(input bit give_ack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      q(); scl = 1'b1; q(); b[i] = sda_line; scl = 1'b0;
    end
    q(); sda_m = give_ack ? 1'b0 : 1'b1; q(); scl = 1'b1; q(); scl = 1'b0; q();
    sda_m = 1'b1;
  endtask

  function automatic logic [7:0] dev_byte(input bit rd);
    return {4'b1010, dev_sel, rd};
  endfunction

  task automatic write_run(input logic [15:0] a, input int n, input logic [7:0] base,
                           output int nacks);
    bit ak;
    nacks = 0;
    bus_start();
    send_byte(dev_byte(1'b0), ak); if (!ak) nacks++;
    send_byte(a[15:8], ak);        if (!ak) nacks++;
    send_byte(a[7:0], ak);         if (!ak) nacks++;
    for (int k = 0; k < n; k++) begin
      send_byte(base + 8'(k), ak); if (!ak) nacks++;
    end
    bus_stop();
  endtask

  task automatic read_run(input logic [15:0] a, input int n, output int nacks);
    bit ak;
    logic [7:0] b;
    nacks = 0;
    bus_start();
    send_byte(dev_byte(1'b0), ak); if (!ak) nacks++;
    send_byte(a[15:8], ak);        if (!ak) nacks++;
    send_byte(a[7:0], ak);         if (!ak) nacks++;
    bus_start();
    send_byte(dev_byte(1'b1), ak); if (!ak) nacks++;
    for (int k = 0; k < n; k++) begin
      recv_byte(k != n - 1, b);
      rd_q[k] = b;
    end
    bus_stop();
  endtask

  task automatic wait_prog();
    repeat (PROG + 40) @(negedge clk);
  endtask

  task automatic probe_ack(input string req, input bit expect_ack);
    bit ak;
    bus_start();
    send_byte(dev_byte(1'b0), ak);
    bus_stop();
    chk(req, ak, expect_ack);
  endtask

  task automatic t_page_write();
    int nk;
    write_run(16'h0123, 4, 8'hA0, nk);
    chk("R4 write bytes acknowledged", nk, 0);
    probe_ack("R7 no ack while programming", 1'b0);
    wait_prog();
    probe_ack("R7 ack after interval", 1'b1);
    read_run(16'h0123, 4, nk);
    chk("R3 matching address acked", nk, 0);
    for (int k = 0; k < 4; k++) chk("R6 R10 page data read back", rd_q[k], 8'hA0 + k);
  endtask

  task automatic t_mismatch();
    bit ak;
    bus_start(); send_byte({4'b1010, 3'b100, 1'b0}, ak); bus_stop();
    chk("R3 strap mismatch no ack", ak, 0);
    bus_start(); send_byte({4'b1011, dev_sel, 1'b0}, ak); bus_stop();
    chk("R3 type mismatch no ack", ak, 0);
  endtask

  task automatic t_no_start();
    bit ak;
    send_byte(dev_byte(1'b0), ak);
    chk("R2 byte without START ignored", ak, 0);
    chk("R2 SDA released", sda_pull, 0);
  endtask

  task automatic t_wrap();
    int nk;
    write_run(16'h003E, 4, 8'hB0, nk); wait_prog();
    read_run(16'h0020, 2, nk);
    chk("R6 wrapped byte at page start", rd_q[0], 8'hB2);
    chk("R6 wrapped byte at page start+1", rd_q[1], 8'hB3);
    read_run(16'h003E, 2, nk);
    chk("R6 byte at page offset 30", rd_q[0], 8'hB0);
    chk("R6 byte at page offset 31", rd_q[1], 8'hB1);
    write_run(16'h0040, 33, 8'h10, nk); wait_prog();
    read_run(16'h0040, 2, nk);
    chk("R6 overwritten offset 0", rd_q[0], 8'h30);
    chk("R6 offset 1 kept", rd_q[1], 8'h11);
  endtask

  task automatic t_wp();
    int nk;
    wp = 1'b1;
    write_run(16'h0123, 1, 8'h55, nk);
    chk("R8 bytes acked under protect", nk, 0);
    probe_ack("R8 no busy interval", 1'b1);
    wp = 1'b0;
    read_run(16'h0123, 1, nk);
    chk("R8 array unchanged", rd_q[0], 8'hA0);
  endtask

  task automatic t_upper();
    int nk;
    read_run(16'hF124, 1, nk);
    chk("R5 upper pointer bits ignored", rd_q[0], 8'hA1);
  endtask

  task automatic t_seq_wrap();
    int nk;
    write_run(16'h0FFF, 1, 8'h77, nk); wait_prog();
    write_run(16'h0000, 1, 8'h88, nk); wait_prog();
    read_run(16'h0FFF, 2, nk);
    chk("R9 last address", rd_q[0], 8'h77);
    chk("R9 wrap to address 0", rd_q[1], 8'h88);
  endtask

  task automatic t_nack();
    bit ak;
    logic [7:0] b;
    int nk;
    bus_start();
    send_byte(dev_byte(1'b0), ak); send_byte(8'h01, ak); send_byte(8'h23, ak);
    bus_start();
    send_byte(dev_byte(1'b1), ak);
    recv_byte(1'b0, b);
    chk("R9 first byte before nack", b, 8'hA0);
    recv_byte(1'b0, b);
    chk("R9 released after nack", b, 8'hFF);
    bus_stop();
    read_run(16'h0125, 1, nk);
    chk("R12 fresh read after stop", rd_q[0], 8'hA2);
  endtask

  task automatic t_discard();
    bit ak;
    int nk;
    bus_start();
    send_byte(dev_byte(1'b0), ak); send_byte(8'h01, ak); send_byte(8'h23, ak);
    send_byte(8'h99, ak);
    bus_start();
    bus_stop();
    probe_ack("R11 no programming after discard", 1'b1);
    read_run(16'h0123, 1, nk);
    chk("R11 array unchanged", rd_q[0], 8'hA0);
  endtask

  task automatic t_conditions();
    bit ak;
    bus_start();
    send_bits(8'hA0, 3);
    bus_start();
    send_byte(dev_byte(1'b0), ak);
    bus_stop();
    chk("R1 START mid-byte restarts address", ak, 1);
    bus_start();
    send_byte(dev_byte(1'b0), ak); send_byte(8'h02, ak);
    bus_stop();
    chk("R12 SDA released after stop", sda_pull, 0);
    probe_ack("R12 idle after partial write", 1'b1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL R12 watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    q();
    chk("R12 reset releases SDA", sda_pull, 0);
    t_page_write();
    t_mismatch();
    t_no_start();
    t_wrap();
    t_wp();
    t_upper();
    t_seq_wrap();
    t_nack();
    t_discard();
    t_conditions();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule